// File: doc/BRIEF.md
# General-Purpose I/O Port Register Bank

This block is an eight-pin general-purpose I/O port that sits on a simple processor data bus. Software controls three per-pin registers: a direction register that decides whether each pin drives, an output latch that holds the value driven, and an analog-select register that cuts the digital input path of pins used for analog signals. Two addresses write the same output latch. Two different addresses read it back: one returns the stored latch value and the other returns the level actually present on the pins.

Each pin can be taken over by an on-chip peripheral through a per-pin override. While the override is active, the peripheral's enable and data drive the pad, and the GPIO registers keep their contents. Pad inputs pass through a two-stage synchronizer. The synchronized level, masked by analog select, is returned on a pin-level read and is also handed to peripherals.

Top module: `gpio_port_bank`

## Requirements
- R1: After reset, every direction bit is 1 (input), every analog-select bit is 1, and the output latch is 0. As a result, `pad_oe` is all zero and a pin-level read returns 0.
- R2: A bus write to address 2 (latch) loads `bus_wdata` into the output latch on the next clock edge. A read of address 2 then returns that value.
- R3: A bus write to address 1 (pin level) loads the same output latch, exactly as a write to address 2 does.
- R4: A read of address 2 returns the stored latch value whatever the pad levels are.
- R5: A read of address 1 returns the pad input level of each digital pin, delayed by two clock edges through the synchronizer.
- R6: A pin whose analog-select bit is 1 reads as 0 at address 1 and drives 0 on `dig_in`, whatever its pad level.
- R7: With no override, a pin whose direction bit is 0 has `pad_oe` 1 and `pad_out` equal to its latch bit. A pin whose direction bit is 1 has `pad_oe` 0.
- R8: While `ovr_en` is 1 for a pin, `pad_oe` and `pad_out` for that pin follow `ovr_oe` and `ovr_out`. The direction and latch registers read back unchanged.
- R9: Address 0 reads and writes the direction register, and address 3 reads and writes the analog-select register.
- R10: Writes to addresses 4 to 7 change no register, and reads of those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized inside |
| bus_addr | input | 3 | Register address: 0 direction, 1 pin level, 2 latch, 3 analog select |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| pad_in | input | 8 | Level seen on each pad |
| pad_oe | output | 8 | Per-pin output-driver enable |
| pad_out | output | 8 | Per-pin output data |
| ovr_en | input | 8 | Per-pin peripheral takeover |
| ovr_oe | input | 8 | Peripheral output enable for taken-over pins |
| ovr_out | input | 8 | Peripheral output data for taken-over pins |
| dig_in | output | 8 | Synchronized digital input to peripherals, 0 on analog pins |

## Verification
The assertions assume that `bus_addr`, `bus_wr` and `bus_wdata` are stable around each rising edge. They also assume that a pin-level read is only trusted two edges after a pad change. The bench changes every input on the falling edge, holds `pad_in` for at least two rising edges before it reads address 1, and issues each write as a one-cycle strobe. Under these conditions, the latch checks, the alias checks and the analog mask checks all compare settled values.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  // Register selector, taken from the low two address bits
  typedef enum logic [1:0] {
    SEL_DIR  = 2'd0,
    SEL_PIN  = 2'd1,
    SEL_LAT  = 2'd2,
    SEL_ANA  = 2'd3
  } reg_sel_e;

  localparam int unsigned SEL_BITS = 2;

endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WIDTH-1:0]  wr_data,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  lat_q,
  output logic [WIDTH-1:0]  ana_q
);

  localparam int unsigned HI_W = ADDR_W - SEL_BITS;

  logic        in_window;
  reg_sel_e    sel;
  logic        dir_we;
  logic        lat_we;
  logic        ana_we;
  logic [WIDTH-1:0] dir_d;
  logic [WIDTH-1:0] lat_d;
  logic [WIDTH-1:0] ana_d;

  generate
    if (HI_W > 0) begin : g_hi
      assign in_window = (wr_addr[ADDR_W-1:SEL_BITS] == '0);
    end else begin : g_nohi
      assign in_window = 1'b1;
    end
  endgenerate

  assign sel = reg_sel_e'(wr_addr[SEL_BITS-1:0]);

  // Write decode: both pin-level and latch addresses reach the latch
  always_comb begin
    dir_we = 1'b0;
    lat_we = 1'b0;
    ana_we = 1'b0;
    if (wr_en && in_window) begin
      unique case (sel)
        SEL_DIR: dir_we = 1'b1;
        SEL_PIN: lat_we = 1'b1;
        SEL_LAT: lat_we = 1'b1;
        SEL_ANA: ana_we = 1'b1;
        default: ;
      endcase
    end
  end

  always_comb begin
    dir_d = dir_we ? wr_data : dir_q;
    lat_d = lat_we ? wr_data : lat_q;
    ana_d = ana_we ? wr_data : ana_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '1;
      lat_q <= '0;
      ana_q <= '1;
    end else begin
      if (dir_we) dir_q <= dir_d;
      if (lat_we) lat_q <= lat_d;
      if (ana_we) ana_q <= ana_d;
    end
  end

  AST_LAT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(2)) |=> (lat_q == $past(wr_data))); // R2
  AST_PIN_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == ADDR_W'(1)) |=> (lat_q == $past(wr_data))); // R3
  AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr > ADDR_W'(3)) |=> ($stable(dir_q) && $stable(lat_q) && $stable(ana_q))); // R10
  AST_LAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && (wr_addr == ADDR_W'(1) || wr_addr == ADDR_W'(2)))) |=> $stable(lat_q)); // R2

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pad_in,
  input  logic [WIDTH-1:0] ana_sel,
  output logic [WIDTH-1:0] pin_level,
  output logic [WIDTH-1:0] dig_level
);

  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_pin
      logic [STAGES-1:0] stage_q;
      logic [STAGES-1:0] stage_d;

      always_comb begin
        stage_d = {stage_q[STAGES-2:0], pad_in[gi]};
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage_q <= '0;
        end else begin
          stage_q <= stage_d;
        end
      end

      // Analog pins have their digital receiver cut off
      assign dig_level[gi] = stage_q[STAGES-1] & ~ana_sel[gi];
    end
  endgenerate

  assign pin_level = dig_level;

endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] lat_q,
  input  logic [WIDTH-1:0] ovr_en,
  input  logic [WIDTH-1:0] ovr_oe,
  input  logic [WIDTH-1:0] ovr_out,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_out
);

  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_pin
      always_comb begin
        if (ovr_en[gi]) begin
          pad_oe[gi]  = ovr_oe[gi];
          pad_out[gi] = ovr_out[gi];
        end else begin
          pad_oe[gi]  = ~dir_q[gi];
          pad_out[gi] = lat_q[gi];
        end
      end
    end
  endgenerate

endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH      = 8,
  parameter int unsigned ADDR_W     = 3,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pad_in,
  output logic [WIDTH-1:0]  pad_oe,
  output logic [WIDTH-1:0]  pad_out,
  input  logic [WIDTH-1:0]  ovr_en,
  input  logic [WIDTH-1:0]  ovr_oe,
  input  logic [WIDTH-1:0]  ovr_out,
  output logic [WIDTH-1:0]  dig_in
);

  logic             rst_i_n;
  logic [WIDTH-1:0] dir_q;
  logic [WIDTH-1:0] lat_q;
  logic [WIDTH-1:0] ana_q;
  logic [WIDTH-1:0] pin_level;
  logic             rd_window;

  gpio_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  gpio_regfile #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) i_regfile (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .wr_en   (bus_wr),
    .wr_addr (bus_addr),
    .wr_data (bus_wdata),
    .dir_q   (dir_q),
    .lat_q   (lat_q),
    .ana_q   (ana_q)
  );

  gpio_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_DEPTH)) i_in_sync (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .pad_in    (pad_in),
    .ana_sel   (ana_q),
    .pin_level (pin_level),
    .dig_level (dig_in)
  );

  gpio_pad_mux #(.WIDTH(WIDTH)) i_pad_mux (
    .dir_q   (dir_q),
    .lat_q   (lat_q),
    .ovr_en  (ovr_en),
    .ovr_oe  (ovr_oe),
    .ovr_out (ovr_out),
    .pad_oe  (pad_oe),
    .pad_out (pad_out)
  );

  generate
    if (ADDR_W > SEL_BITS) begin : g_rd_hi
      assign rd_window = (bus_addr[ADDR_W-1:SEL_BITS] == '0);
    end else begin : g_rd_nohi
      assign rd_window = 1'b1;
    end
  endgenerate

  // Combinational read path
  always_comb begin
    bus_rdata = '0;
    if (rd_window) begin
      unique case (reg_sel_e'(bus_addr[SEL_BITS-1:0]))
        SEL_DIR: bus_rdata = dir_q;
        SEL_PIN: bus_rdata = pin_level;
        SEL_LAT: bus_rdata = lat_q;
        SEL_ANA: bus_rdata = ana_q;
        default: bus_rdata = '0;
      endcase
    end
  end

  AST_ANALOG_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_i_n)
    (bus_addr == ADDR_W'(1)) |-> ((bus_rdata & ana_q) == '0)); // R6
  AST_OVR_KEEPS_DIR: assert property (@(posedge clk) disable iff (!rst_i_n)
    (!bus_wr) |=> $stable(dir_q)); // R8

endmodule

// File: tb/test_gpio_port_bank.sv
module test_gpio_port_bank;

  logic       clk;
  logic       rst_n;
  logic [2:0] bus_addr;
  logic       bus_wr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic [7:0] pad_in;
  logic [7:0] pad_oe;
  logic [7:0] pad_out;
  logic [7:0] ovr_en;
  logic [7:0] ovr_oe;
  logic [7:0] ovr_out;
  logic [7:0] dig_in;

  int n_run;
  int n_fail;
  bit done;

  gpio_port_bank i_gpio_port_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_in    (pad_in),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out),
    .ovr_en    (ovr_en),
    .ovr_oe    (ovr_oe),
    .ovr_out   (ovr_out),
    .dig_in    (dig_in)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic set_pads(input logic [7:0] v);
    @(negedge clk);
    pad_in = v;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    logic [7:0] rd;
    n_run = 0; n_fail = 0; done = 0;
    rst_n = 0; bus_addr = 0; bus_wr = 0; bus_wdata = 0;
    pad_in = 8'hA5; ovr_en = 0; ovr_oe = 0; ovr_out = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    bus_read(3'd0, rd); chk("R1 dir", rd, 8'hFF);
    bus_read(3'd3, rd); chk("R1 ana", rd, 8'hFF);
    bus_read(3'd2, rd); chk("R1 lat", rd, 8'h00);
    bus_read(3'd1, rd); chk("R1 pin", rd, 8'h00);
    chk("R1 pad_oe", pad_oe, 8'h00);

    // R9 direction and analog registers
    bus_write(3'd0, 8'h00);
    bus_write(3'd3, 8'h00);
    bus_read(3'd0, rd); chk("R9 dir", rd, 8'h00);
    bus_read(3'd3, rd); chk("R9 ana", rd, 8'h00);

    // R2/R3/R7 latch sweep through both write addresses
    for (int v = 0; v < 256; v++) begin
      bus_write((v % 2 == 0) ? 3'd2 : 3'd1, 8'(v));
      bus_read(3'd2, rd);
      chk((v % 2 == 0) ? "R2 latch" : "R3 alias", rd, 8'(v));
      chk("R7 pad_out", pad_out, 8'(v));
      chk("R7 pad_oe", pad_oe, 8'hFF);
    end

    // R5 pin-level sweep, R4 latch unaffected by pads
    bus_write(3'd2, 8'h3C);
    for (int v = 0; v < 256; v++) begin
      set_pads(8'(v));
      bus_read(3'd1, rd); chk("R5 pin", rd, 8'(v));
      chk("R5 dig_in", dig_in, 8'(v));
      bus_read(3'd2, rd); chk("R4 latch", rd, 8'h3C);
    end

    // R5 latency: after one edge the old value still shows
    set_pads(8'h00);
    @(negedge clk); pad_in = 8'hFF;
    @(negedge clk);
    bus_read(3'd1, rd); chk("R5 one edge", rd, 8'h00);
    @(negedge clk);
    bus_read(3'd1, rd); chk("R5 two edges", rd, 8'hFF);

    // R6 analog mask sweep
    set_pads(8'hFF);
    for (int m = 0; m < 256; m++) begin
      bus_write(3'd3, 8'(m));
      bus_read(3'd1, rd); chk("R6 pin mask", rd, ~8'(m));
      chk("R6 dig_in", dig_in, ~8'(m));
    end
    bus_write(3'd3, 8'h00);

    // R7 direction sweep
    bus_write(3'd2, 8'h5A);
    for (int d = 0; d < 256; d++) begin
      bus_write(3'd0, 8'(d));
      chk("R7 oe by dir", pad_oe, ~8'(d));
      chk("R7 out", pad_out, 8'h5A);
    end

    // R8 override
    bus_write(3'd0, 8'h0F);
    for (int e = 0; e < 256; e += 17) begin
      @(negedge clk);
      ovr_en = 8'(e); ovr_oe = 8'hC3; ovr_out = 8'h96;
      #1;
      chk("R8 oe", pad_oe, (8'(e) & 8'hC3) | (~8'(e) & 8'hF0));
      chk("R8 out", pad_out, (8'(e) & 8'h96) | (~8'(e) & 8'h5A));
      bus_read(3'd0, rd); chk("R8 dir kept", rd, 8'h0F);
      bus_read(3'd2, rd); chk("R8 lat kept", rd, 8'h5A);
    end
    @(negedge clk); ovr_en = 0;

    // R10 unmapped addresses
    for (int a = 4; a < 8; a++) begin
      bus_write(3'(a), 8'hE7);
      bus_read(3'(a), rd); chk("R10 read zero", rd, 8'h00);
      bus_read(3'd0, rd); chk("R10 dir", rd, 8'h0F);
      bus_read(3'd2, rd); chk("R10 lat", rd, 8'h5A);
      bus_read(3'd3, rd); chk("R10 ana", rd, 8'h00);
    end

    done = 1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule